// File: doc/BRIEF.md
# Run-to-Completion Interrupt Dispatcher

This controller decides which code context owns a small 8-bit core at each hand-off point. There is no preemption and no stack. An interrupt service routine runs until the core signals that it has finished. The main program keeps the core until it yields on purpose. At every hand-off the dispatcher picks the next context and sends the core a one-cycle program-counter load strobe with the entry address. It also reports which context is now active.

The core sends the dispatcher two kinds of pulse. A completion pulse comes from its return instruction. A yield pulse comes from its break instruction, together with a wait bit.

A yield always enters a dedicated break-service entry first. The completion of that entry is a release point like any other. At each release point the lowest-numbered pending request wins. When nothing is pending, the main program resumes at the address it captured when it yielded. If the main program yielded with the wait bit set, it resumes only after at least one service routine has been dispatched.

A reduced variant has no main program. In that variant the core idles until a request arrives, and every target falls in F000–FFFF.

Top module: `rtc_dispatch`

## Requirements
- R1: While an ISR context (code 2) is active and no completion pulse arrives, the context, its index and the strobe stay unchanged. New requests wait as pending.
- R2: While the main context (code 0) is active, only a yield pulse ends it. Requests never interrupt it.
- R3: At a release point, the lowest-numbered pending line is dispatched. The load strobe rises in the cycle after the release pulse, and the target is F000 + 16 × line index.
- R4: A yield pulse in the main context loads the break-service entry F000 + 16 × N_IRQ (F040 for four lines) and reports context code 3. It also captures the resume address on that edge.
- R5: If nothing is pending when control is released and the wait bit was 0 at the yield, the main program resumes at the captured address.
- R6: If the wait bit was 1 at the yield and nothing is pending at release, the context becomes idle (code 1) with no load. The next request is then dispatched, and the main program resumes after that ISR completes.
- R7: A rising edge on a request line sets a sticky pending bit, and dispatching that line clears it. A line held high does not retrigger. Edges that arrive during another context are not lost.
- R8: During reset the strobe is 0 and the context is idle. On the first clock edge after reset, the main variant loads reset vector E000 in context main.
- R9: The variant without a main program stays idle after reset, never reports context main, ignores yield pulses, and only ever targets F000–FFFF.
- R10: Stray pulses are ignored. A completion pulse in main or idle has no effect, and neither does a yield pulse in an ISR or break-service context.
- R11: Context codes are main 0, idle 1, ISR 2 (line on the index port) and break service 3. The strobe lasts one cycle per dispatch and never appears with the idle code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | N_IRQ | Request lines, rising-edge sensitive |
| rti_i | input | 1 | Completion pulse from the return instruction |
| brk_i | input | 1 | Yield pulse from the break instruction |
| brk_wait_i | input | 1 | Yield mode: 1 parks main until an ISR has run |
| resume_addr_i | input | ADDR_W | Main-program resume address, sampled at yield |
| pc_load_o | output | 1 | One-cycle program-counter load strobe |
| pc_target_o | output | ADDR_W | Address to load when the strobe is high |
| ctx_kind_o | output | 2 | Active context code |
| ctx_idx_o | output | IDX_W | Active ISR line when the code is 2 |

## Verification
The hardest state to reach is the parked main program. Getting there takes a yield with the wait bit set and a release with nothing pending. A request must then arrive while the core is idle, and the resume must happen only after that ISR completes. The stimulus also raises several lines while a yield is being serviced. It sweeps all fifteen non-empty request patterns and expects the ISRs in ascending line order followed by the main resume. A separate instance without a main program exercises the idle-only flow.

// File: rtl/rtcd_pkg.sv
package rtcd_pkg;
    typedef enum logic [1:0] {
        CTX_MAIN = 2'd0,
        CTX_IDLE = 2'd1,
        CTX_ISR  = 2'd2,
        CTX_BRK  = 2'd3
    } ctx_e;
endpackage

// File: rtl/rtcd_pending.sv
// Sticky pending bits set on request rising edges.
module rtcd_pending #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } pst_t;

    pst_t q, d;
    logic [N-1:0] rise;

    always_comb begin
        rise   = irq_i & ~q.prev;
        d.prev = irq_i;
        d.pend = (q.pend | rise) & ~clr_i;
        pend_o = q.pend | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rtcd_prio.sv
// Fixed priority pick: lowest index wins.
module rtcd_prio #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     onehot_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        onehot_o = any_o ? (N'(1) << idx_o) : '0;
    end
endmodule

// File: rtl/rtcd_vec.sv
// Entry address table for the ISR slots and the break-service slot.
module rtcd_vec #(
    parameter int                N          = 4,
    parameter int                IDX_W      = 2,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE   = 16'hF000,
    parameter int                SLOT_SHIFT = 4
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] isr_addr_o,
    output logic [ADDR_W-1:0] brk_addr_o
);
    logic [ADDR_W-1:0] tbl [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign tbl[g] = VEC_BASE + (ADDR_W'(g) << SLOT_SHIFT);
    end

    assign isr_addr_o = tbl[idx_i];
    assign brk_addr_o = VEC_BASE + (ADDR_W'(N) << SLOT_SHIFT);
endmodule

// File: rtl/rtc_dispatch.sv
// Run-to-completion context dispatcher.
module rtc_dispatch #(
    parameter int                N_IRQ      = 4,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE   = 16'hF000,
    parameter int                SLOT_SHIFT = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC  = 16'hE000,
    parameter bit                HAS_MAIN   = 1'b1,
    localparam int               IDX_W      = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_i,
    input  logic              rti_i,
    input  logic              brk_i,
    input  logic              brk_wait_i,
    input  logic [ADDR_W-1:0] resume_addr_i,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_target_o,
    output logic [1:0]        ctx_kind_o,
    output logic [IDX_W-1:0]  ctx_idx_o
);
    import rtcd_pkg::*;

    localparam logic [ADDR_W-1:0] FORCE_HI = {4'hF, {(ADDR_W-4){1'b0}}};

    typedef struct packed {
        ctx_e              kind;
        logic [IDX_W-1:0]  idx;
        logic              boot;
        logic              park;
        logic [ADDR_W-1:0] resume;
        logic              load;
        logic [ADDR_W-1:0] target;
    } st_t;

    st_t q, d;

    logic [N_IRQ-1:0]  pend, clr, win_oh;
    logic              any;
    logic [IDX_W-1:0]  win;
    logic [ADDR_W-1:0] isr_addr, brk_addr;
    logic              release_ev, yield_ev;

    function automatic logic [ADDR_W-1:0] fold(input logic [ADDR_W-1:0] a);
        return HAS_MAIN ? a : (a | FORCE_HI);
    endfunction

    rtcd_pending #(.N(N_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_i(clr), .pend_o(pend)
    );

    rtcd_prio #(.N(N_IRQ), .IDX_W(IDX_W)) u_prio (
        .req_i(pend), .any_o(any), .idx_o(win), .onehot_o(win_oh)
    );

    rtcd_vec #(
        .N(N_IRQ), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
        .VEC_BASE(VEC_BASE), .SLOT_SHIFT(SLOT_SHIFT)
    ) u_vec (
        .idx_i(win), .isr_addr_o(isr_addr), .brk_addr_o(brk_addr)
    );

    always_comb begin
        d          = q;
        d.load     = 1'b0;
        clr        = '0;
        release_ev = rti_i && (q.kind == CTX_ISR || q.kind == CTX_BRK);
        yield_ev   = HAS_MAIN && brk_i && (q.kind == CTX_MAIN);

        if (q.boot) begin
            d.boot   = 1'b0;
            d.kind   = CTX_MAIN;
            d.idx    = '0;
            d.load   = 1'b1;
            d.target = RESET_VEC;
        end else if (yield_ev) begin
            d.resume = resume_addr_i;
            d.park   = brk_wait_i;
            d.kind   = CTX_BRK;
            d.idx    = '0;
            d.load   = 1'b1;
            d.target = fold(brk_addr);
        end else if (release_ev || q.kind == CTX_IDLE) begin
            if (any) begin
                d.kind   = CTX_ISR;
                d.idx    = win;
                d.load   = 1'b1;
                d.target = fold(isr_addr);
                d.park   = 1'b0;
                clr      = win_oh;
            end else if (release_ev) begin
                if (HAS_MAIN && !q.park) begin
                    d.kind   = CTX_MAIN;
                    d.idx    = '0;
                    d.load   = 1'b1;
                    d.target = q.resume;
                end else begin
                    d.kind = CTX_IDLE;
                    d.idx  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.kind <= CTX_IDLE;
            q.boot <= HAS_MAIN;
        end else begin
            q <= d;
        end
    end

    assign pc_load_o   = q.load;
    assign pc_target_o = q.target;
    assign ctx_kind_o  = q.kind;
    assign ctx_idx_o   = q.idx;
endmodule

// File: rtl/rtc_dispatch_chk.sv
module rtc_dispatch_chk #(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 2,
    parameter bit HAS_MAIN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rti_i,
    input logic              brk_i,
    input logic              pc_load_o,
    input logic [ADDR_W-1:0] pc_target_o,
    input logic [1:0]        ctx_kind_o,
    input logic [IDX_W-1:0]  ctx_idx_o
);
    p_isr_no_preempt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_kind_o == 2'd2 && !rti_i) |=> (ctx_kind_o == 2'd2 && $stable(ctx_idx_o) && !pc_load_o));

    p_main_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_kind_o == 2'd0 && !brk_i) |=> (ctx_kind_o == 2'd0 && !pc_load_o));

    p_isr_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && ctx_kind_o == 2'd2) |-> (pc_target_o[ADDR_W-1 -: 4] == 4'hF && pc_target_o[3:0] == 4'h0));

    p_yield_brk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_kind_o == 2'd0 && brk_i) |=> (pc_load_o && ctx_kind_o == 2'd3));

    p_no_main_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_MAIN) |-> (ctx_kind_o != 2'd0 && (!pc_load_o || pc_target_o[ADDR_W-1 -: 4] == 4'hF)));

    p_brk_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_kind_o == 2'd3 && !rti_i) |=> (ctx_kind_o == 2'd3 && !pc_load_o));

    p_idle_no_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_kind_o == 2'd1) |-> !pc_load_o);
endmodule

bind rtc_dispatch rtc_dispatch_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HAS_MAIN(HAS_MAIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rti_i(rti_i), .brk_i(brk_i),
    .pc_load_o(pc_load_o), .pc_target_o(pc_target_o),
    .ctx_kind_o(ctx_kind_o), .ctx_idx_o(ctx_idx_o)
);

// File: tb/rtc_dispatch_test.sv
module rtc_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_MAIN = 2'd0, K_IDLE = 2'd1, K_ISR = 2'd2, K_BRK = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  irq = '0, nm_irq = '0;
    logic        rti = 0, brk = 0, bwait = 0, nm_rti = 0, nm_brk = 0;
    logic [15:0] resume = '0;

    logic        ld, nm_ld;
    logic [15:0] tg, nm_tg;
    logic [1:0]  kd, nm_kd, ix, nm_ix;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_dispatch uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .rti_i(rti), .brk_i(brk),
        .brk_wait_i(bwait), .resume_addr_i(resume), .pc_load_o(ld),
        .pc_target_o(tg), .ctx_kind_o(kd), .ctx_idx_o(ix)
    );

    rtc_dispatch #(.HAS_MAIN(1'b0)) uut_nm (
        .clk(clk), .rst_n(rst_n), .irq_i(nm_irq), .rti_i(nm_rti), .brk_i(nm_brk),
        .brk_wait_i(1'b0), .resume_addr_i(16'h1111), .pc_load_o(nm_ld),
        .pc_target_o(nm_tg), .ctx_kind_o(nm_kd), .ctx_idx_o(nm_ix)
    );

    function automatic logic [15:0] isr_vec(int i);
        return 16'hF000 + 16'(i * 16);
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic a_ld, logic [15:0] a_tg, logic [1:0] a_k, logic [1:0] a_i,
                       logic e_ld, logic [15:0] e_tg, logic [1:0] e_k, logic [1:0] e_i);
        bit ok;
        ok = (a_ld == e_ld) && (!e_ld || a_tg == e_tg) && (a_k == e_k) && (e_k != K_ISR || a_i == e_i);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got load=%0b tgt=%h ctx=%0d idx=%0d, expected load=%0b tgt=%h ctx=%0d idx=%0d",
                     req, a_ld, a_tg, a_k, a_i, e_ld, e_tg, e_k, e_i);
        end
    endtask

    task automatic cm(string req, logic e_ld, logic [15:0] e_tg, logic [1:0] e_k, logic [1:0] e_i);
        chk(req, ld, tg, kd, ix, e_ld, e_tg, e_k, e_i);
    endtask

    task automatic cn(string req, logic e_ld, logic [15:0] e_tg, logic [1:0] e_k, logic [1:0] e_i);
        chk(req, nm_ld, nm_tg, nm_kd, nm_ix, e_ld, e_tg, e_k, e_i);
    endtask

    task automatic do_rti();
        rti = 1; step(); rti = 0;
    endtask

    task automatic do_brk(logic w, logic [15:0] ra);
        bwait = w; resume = ra; brk = 1; step(); brk = 0; bwait = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        cm("R8 reset state", 0, 0, K_IDLE, 0);
        cn("R8 reset state no-main", 0, 0, K_IDLE, 0);
        rst_n = 1;
        step();
        cm("R8 boot vector", 1, 16'hE000, K_MAIN, 0);
        cn("R9 idle after reset", 0, 0, K_IDLE, 0);
        step();
        cm("R11 single-cycle strobe", 0, 0, K_MAIN, 0);

        irq = 4'b0100;
        step(); step(); step();
        cm("R2 main not interrupted", 0, 0, K_MAIN, 0);
        rti = 1; step(); rti = 0;
        cm("R10 stray completion in main", 0, 0, K_MAIN, 0);

        do_brk(0, 16'h1234);
        cm("R4 yield to break entry", 1, 16'hF040, K_BRK, 0);
        brk = 1; step(); brk = 0;
        cm("R10 yield ignored in break service", 0, 0, K_BRK, 0);
        do_rti();
        cm("R3 dispatch pending line 2", 1, isr_vec(2), K_ISR, 2);

        irq = 4'b0111;
        step();
        cm("R1 no preemption by higher lines", 0, 0, K_ISR, 2);
        brk = 1; step(); brk = 0;
        cm("R10 yield ignored in ISR", 0, 0, K_ISR, 2);
        do_rti();
        cm("R3 priority line 0 first", 1, isr_vec(0), K_ISR, 0);
        do_rti();
        cm("R7 edge during ISR kept, line 1", 1, isr_vec(1), K_ISR, 1);
        do_rti();
        cm("R5 resume at captured address", 1, 16'h1234, K_MAIN, 0);

        do_brk(0, 16'h1300);
        do_rti();
        cm("R7 held level does not retrigger", 1, 16'h1300, K_MAIN, 0);

        irq = '0;
        step();
        do_brk(1, 16'h2000);
        cm("R4 yield in wait mode", 1, 16'hF040, K_BRK, 0);
        do_rti();
        cm("R6 parked main goes idle", 0, 0, K_IDLE, 0);
        step(); step();
        rti = 1; step(); rti = 0;
        cm("R10 stray completion in idle", 0, 0, K_IDLE, 0);
        irq[3] = 1;
        step();
        cm("R6 request dispatched from idle", 1, isr_vec(3), K_ISR, 3);
        do_rti();
        cm("R6 main resumes after ISR", 1, 16'h2000, K_MAIN, 0);

        for (int p = 1; p < 16; p++) begin
            irq = '0;
            step();
            do_brk(0, 16'h4000 + 16'(p));
            irq = 4'(p);
            step();
            cm("R1 break service not preempted", 0, 0, K_BRK, 0);
            for (int i = 0; i < 4; i++) begin
                if (p[i]) begin
                    do_rti();
                    cm("R3 sweep priority order", 1, isr_vec(i), K_ISR, 2'(i));
                end
            end
            do_rti();
            cm("R5 sweep resume", 1, 16'h4000 + 16'(p), K_MAIN, 0);
        end

        nm_brk = 1; step(); nm_brk = 0;
        cn("R9 yield ignored without main", 0, 0, K_IDLE, 0);
        nm_rti = 1; step(); nm_rti = 0;
        cn("R10 stray completion no-main idle", 0, 0, K_IDLE, 0);
        nm_irq = 4'b1010;
        step();
        cn("R9 dispatch line 1 no-main", 1, isr_vec(1), K_ISR, 1);
        nm_rti = 1; step(); nm_rti = 0;
        cn("R9 dispatch line 3 no-main", 1, isr_vec(3), K_ISR, 3);
        nm_rti = 1; step(); nm_rti = 0;
        cn("R9 back to idle", 0, 0, K_IDLE, 0);
        step();
        cn("R11 idle stays quiet", 0, 0, K_IDLE, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule